// File: doc/BRIEF.md
# Non-Binding Prefetch Issuer

This block sits beside the load and store queues of a core whose memory ordering rules sometimes force accesses to wait. For every access that is waiting on those rules, it can start a non-binding prefetch so that the line is already in the cache when the access is finally allowed to perform. Loads ask for a shared copy. Stores and atomic read-modify-writes ask for exclusive ownership, but only when the coherence scheme invalidates other copies. When the scheme propagates updates instead, write prefetching is switched off.

Qualified candidates wait in a small in-order prefetch buffer. When the buffer is full, a new candidate is dropped and the pipeline does not stall. The head of the buffer probes the cache tags. On a hit, meaning the line is present in a sufficient state, the request is discarded. A request whose line is already being fetched is also discarded. Any other request goes to memory and takes a slot in a small miss table. When the memory response returns, the block tells the cache to fill the line and frees the slot.

A demand access to a line that still has a prefetch in flight is merged onto that prefetch. The block raises no second memory request for it and reports completion when the prefetch data arrives.

Top module: `pf_issuer`

## Requirements
- R1: A candidate enters the prefetch buffer only when `cand_valid` and `cand_held` are both 1 and `cand_kind` is not 3. A candidate with `cand_held`=0 or with kind 3 is ignored.
- R2: The kind codes are 0 for load, 1 for store and 2 for atomic. A load prefetch probes and requests with the exclusive flag at 0. A store or atomic prefetch uses the exclusive flag at 1.
- R3: While `update_mode` is 1, store and atomic candidates are ignored and load candidates are still accepted.
- R4: `probe_valid` is 1 exactly when the buffer is not empty, `mem_req_ready` is 1 and the miss table has a free slot. The buffer presents requests in arrival order and removes the head in each cycle with `probe_valid` and `probe_ready` both 1.
- R5: A probe accepted with `probe_hit`=1 is discarded and raises no memory request.
- R6: A probe accepted with `probe_hit`=0 for a line not in flight raises `mem_req_valid` in the same cycle, with the probe's line and exclusive flag.
- R7: A probe accepted for a line that already has a request in flight raises no memory request.
- R8: A memory response for a line in flight gives one cycle of `fill_valid` on the next cycle, carrying that line and its exclusive flag, and frees the slot. A response for a line not in flight is ignored.
- R9: A demand access to a line in flight raises `dem_merge` in the same cycle and produces no memory request. A demand to any other line gives `dem_merge`=0.
- R10: A candidate that arrives while the buffer holds `FIFO_DEPTH` entries is dropped. Candidates accepted earlier keep their order.
- R11: While every slot of the miss table holds a request in flight, `probe_valid` stays 0. Freeing a slot re-enables probing.
- R12: On the cycle after the response for a merged line, `dem_done` is 1 and `dem_done_line` holds that line. A response for a line with no merged demand leaves `dem_done` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cand_valid | input | 1 | Queue access is presented |
| cand_kind | input | 2 | Access kind: 0 load, 1 store, 2 atomic, 3 none |
| cand_held | input | 1 | Access is delayed by ordering rules |
| cand_line | input | LINE_W | Line address of the access |
| update_mode | input | 1 | 1 when the coherence scheme is update-based |
| probe_valid | output | 1 | Tag probe request |
| probe_line | output | LINE_W | Line address being probed |
| probe_excl | output | 1 | Probe needs exclusive state |
| probe_ready | input | 1 | Cache accepts the probe this cycle |
| probe_hit | input | 1 | Line present in sufficient state (valid with accept) |
| mem_req_valid | output | 1 | Prefetch request to memory |
| mem_req_line | output | LINE_W | Requested line |
| mem_req_excl | output | 1 | Request exclusive ownership |
| mem_req_ready | input | 1 | Memory can take a request |
| mem_rsp_valid | input | 1 | Memory response arrives |
| mem_rsp_line | input | LINE_W | Line of the response |
| fill_valid | output | 1 | Write the returned line into the cache |
| fill_line | output | LINE_W | Line to fill |
| fill_excl | output | 1 | Fill in exclusive state |
| dem_valid | input | 1 | Demand access looks up in-flight prefetches |
| dem_line | input | LINE_W | Demand line address |
| dem_merge | output | 1 | Demand merged onto an in-flight prefetch |
| dem_done | output | 1 | Merged demand completes |
| dem_done_line | output | LINE_W | Line of the completed demand |

## Verification
A candidate is captured at a rising edge, so `probe_valid` and the probe fields are due one edge after the candidate is presented. `mem_req_valid` and `dem_merge` depend combinationally on the current probe acceptance, hit flag and demand lookup, so they are due in the same cycle as their stimulus. `fill_valid`, `dem_done` and the related lines come from registers and are due exactly one edge after `mem_rsp_valid`. Each task drives its inputs on the falling edge and samples 1 ns later. It therefore reads combinational results in the stimulus cycle and registered results after the single edge that loads them, and it removes every request it started before the next scenario begins.

// File: rtl/pfi_pkg.sv
package pfi_pkg;

    parameter int LINE_W = 26;

    typedef enum logic [1:0] {
        ACC_LOAD   = 2'd0,
        ACC_STORE  = 2'd1,
        ACC_ATOMIC = 2'd2,
        ACC_NONE   = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic              excl;
    } pf_req_t;

    typedef struct packed {
        logic              valid;
        logic [LINE_W-1:0] line;
        logic              excl;
        logic              merged;
    } miss_ent_t;

    function automatic logic needs_excl(acc_kind_e k);
        return (k == ACC_STORE) || (k == ACC_ATOMIC);
    endfunction

    function automatic logic kind_allowed(acc_kind_e k, logic upd);
        if (k == ACC_NONE) return 1'b0;
        if (needs_excl(k) && upd) return 1'b0;
        return 1'b1;
    endfunction

endpackage

// File: rtl/pfi_qualify.sv
module pfi_qualify
    import pfi_pkg::*;
(
    input  logic              cand_valid,
    input  logic [1:0]        cand_kind,
    input  logic              cand_held,
    input  logic [LINE_W-1:0] cand_line,
    input  logic              update_mode,
    output logic              push,
    output pf_req_t           push_req
);
    acc_kind_e kind;

    always_comb begin
        kind          = acc_kind_e'(cand_kind);
        push          = cand_valid && cand_held && kind_allowed(kind, update_mode);
        push_req.line = cand_line;
        push_req.excl = needs_excl(kind);
    end
endmodule

// File: rtl/pfi_fifo.sv
module pfi_fifo
    import pfi_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    push,
    input  pf_req_t din,
    input  logic    pop,
    output pf_req_t dout,
    output logic    empty,
    output logic    full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    pf_req_t        slots [DEPTH];
    logic [PW-1:0]  rd_ptr, wr_ptr;
    logic [CW-1:0]  count;
    logic           wr_en, rd_en;

    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));
    assign wr_en = push && !full;
    assign rd_en = pop && !empty;
    assign dout  = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (wr_en) slots[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (rd_en) rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(wr_en) - CW'(rd_en);
        end
    end
endmodule

// File: rtl/pfi_miss_table.sv
module pfi_miss_table
    import pfi_pkg::*;
#(
    parameter int ENTRIES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc,
    input  pf_req_t           alloc_req,
    input  logic [LINE_W-1:0] look_line,
    output logic              look_pending,
    output logic              has_free,
    input  logic              dem_valid,
    input  logic [LINE_W-1:0] dem_line,
    output logic              dem_merge,
    input  logic              rsp_valid,
    input  logic [LINE_W-1:0] rsp_line,
    output logic              fill_valid,
    output logic [LINE_W-1:0] fill_line,
    output logic              fill_excl,
    output logic              done_valid
);
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    miss_ent_t            ent [ENTRIES];
    logic [ENTRIES-1:0]   look_hit, dem_hit, rsp_hit;
    logic [IW-1:0]        free_idx;
    logic                 rsp_excl, rsp_done;

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_match
            assign look_hit[g] = ent[g].valid && (ent[g].line == look_line);
            assign dem_hit[g]  = dem_valid && ent[g].valid && (ent[g].line == dem_line);
            assign rsp_hit[g]  = rsp_valid && ent[g].valid && (ent[g].line == rsp_line);
        end
    endgenerate

    always_comb begin
        free_idx = '0;
        has_free = 1'b0;
        rsp_excl = 1'b0;
        rsp_done = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!ent[i].valid) begin
                free_idx = IW'(i);
                has_free = 1'b1;
            end
        end
        for (int i = 0; i < ENTRIES; i++) begin
            if (rsp_hit[i]) begin
                rsp_excl = rsp_excl | ent[i].excl;
                rsp_done = rsp_done | ent[i].merged | dem_hit[i];
            end
        end
    end

    assign look_pending = |look_hit;
    assign dem_merge    = |dem_hit;

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    ent[g] <= '0;
                end else if (alloc && has_free && (free_idx == IW'(g))) begin
                    ent[g].valid  <= 1'b1;
                    ent[g].line   <= alloc_req.line;
                    ent[g].excl   <= alloc_req.excl;
                    ent[g].merged <= 1'b0;
                end else if (rsp_hit[g]) begin
                    ent[g].valid  <= 1'b0;
                    ent[g].merged <= 1'b0;
                end else if (dem_hit[g]) begin
                    ent[g].merged <= 1'b1;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_valid <= 1'b0;
            fill_line  <= '0;
            fill_excl  <= 1'b0;
            done_valid <= 1'b0;
        end else begin
            fill_valid <= |rsp_hit;
            fill_line  <= rsp_line;
            fill_excl  <= rsp_excl;
            done_valid <= rsp_done;
        end
    end
endmodule

// File: rtl/pf_issuer.sv
module pf_issuer
    import pfi_pkg::*;
#(
    parameter int FIFO_DEPTH  = 4,
    parameter int MISS_SLOTS  = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cand_valid,
    input  logic [1:0]                cand_kind,
    input  logic                      cand_held,
    input  logic [pfi_pkg::LINE_W-1:0] cand_line,
    input  logic                      update_mode,
    output logic                      probe_valid,
    output logic [pfi_pkg::LINE_W-1:0] probe_line,
    output logic                      probe_excl,
    input  logic                      probe_ready,
    input  logic                      probe_hit,
    output logic                      mem_req_valid,
    output logic [pfi_pkg::LINE_W-1:0] mem_req_line,
    output logic                      mem_req_excl,
    input  logic                      mem_req_ready,
    input  logic                      mem_rsp_valid,
    input  logic [pfi_pkg::LINE_W-1:0] mem_rsp_line,
    output logic                      fill_valid,
    output logic [pfi_pkg::LINE_W-1:0] fill_line,
    output logic                      fill_excl,
    input  logic                      dem_valid,
    input  logic [pfi_pkg::LINE_W-1:0] dem_line,
    output logic                      dem_merge,
    output logic                      dem_done,
    output logic [pfi_pkg::LINE_W-1:0] dem_done_line
);
    logic    push, fifo_empty, fifo_full, probe_fire, in_flight, tbl_free;
    pf_req_t push_req, head;

    pfi_qualify u_qual (
        .cand_valid (cand_valid),
        .cand_kind  (cand_kind),
        .cand_held  (cand_held),
        .cand_line  (cand_line),
        .update_mode(update_mode),
        .push       (push),
        .push_req   (push_req)
    );

    pfi_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk  (clk),
        .rst  (rst),
        .push (push),
        .din  (push_req),
        .pop  (probe_fire),
        .dout (head),
        .empty(fifo_empty),
        .full (fifo_full)
    );

    assign probe_valid   = !fifo_empty && mem_req_ready && tbl_free;
    assign probe_line    = head.line;
    assign probe_excl    = head.excl;
    assign probe_fire    = probe_valid && probe_ready;
    assign mem_req_valid = probe_fire && !probe_hit && !in_flight;
    assign mem_req_line  = head.line;
    assign mem_req_excl  = head.excl;

    pfi_miss_table #(.ENTRIES(MISS_SLOTS)) u_tbl (
        .clk         (clk),
        .rst         (rst),
        .alloc       (mem_req_valid),
        .alloc_req   (head),
        .look_line   (head.line),
        .look_pending(in_flight),
        .has_free    (tbl_free),
        .dem_valid   (dem_valid),
        .dem_line    (dem_line),
        .dem_merge   (dem_merge),
        .rsp_valid   (mem_rsp_valid),
        .rsp_line    (mem_rsp_line),
        .fill_valid  (fill_valid),
        .fill_line   (fill_line),
        .fill_excl   (fill_excl),
        .done_valid  (dem_done)
    );

    assign dem_done_line = fill_line;
endmodule

// File: rtl/pfi_checker.sv
module pfi_checker
    import pfi_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              probe_valid,
    input logic              probe_ready,
    input logic              probe_hit,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_rsp_valid,
    input logic              fill_valid,
    input logic              dem_done,
    input logic [LINE_W-1:0] dem_done_line,
    input logic [LINE_W-1:0] fill_line
);
    // R4: probing is gated by memory readiness
    assert_probe_gated_R4: assert property (@(posedge clk) disable iff (rst)
        probe_valid |-> mem_req_ready);

    // R5: an accepted probe that hits never reaches memory
    assert_hit_dropped_R5: assert property (@(posedge clk) disable iff (rst)
        (probe_valid && probe_ready && probe_hit) |-> !mem_req_valid);

    // R6: a memory request only accompanies an accepted, missing probe
    assert_req_from_miss_R6: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (probe_valid && probe_ready && !probe_hit));

    // R8: a fill follows a response by one cycle
    assert_fill_after_rsp_R8: assert property (@(posedge clk) disable iff (rst)
        fill_valid |-> $past(mem_rsp_valid));

    // R12: a completed demand rides on a fill of the same line
    assert_done_with_fill_R12: assert property (@(posedge clk) disable iff (rst)
        dem_done |-> (fill_valid && dem_done_line == fill_line));
endmodule

bind pf_issuer pfi_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .probe_valid  (probe_valid),
    .probe_ready  (probe_ready),
    .probe_hit    (probe_hit),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid),
    .fill_valid   (fill_valid),
    .dem_done     (dem_done),
    .dem_done_line(dem_done_line),
    .fill_line    (fill_line)
);

// File: tb/sim_pf_issuer.sv
`timescale 1ns/1ps
module sim_pf_issuer;
    import pfi_pkg::*;

    localparam int LW = pfi_pkg::LINE_W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cand_valid = 0, cand_held = 0, update_mode = 0;
    logic [1:0]    cand_kind = 0;
    logic [LW-1:0] cand_line = '0;
    logic          probe_valid, probe_excl, probe_ready = 0, probe_hit = 0;
    logic [LW-1:0] probe_line;
    logic          mem_req_valid, mem_req_excl, mem_req_ready = 1;
    logic [LW-1:0] mem_req_line;
    logic          mem_rsp_valid = 0;
    logic [LW-1:0] mem_rsp_line = '0;
    logic          fill_valid, fill_excl;
    logic [LW-1:0] fill_line;
    logic          dem_valid = 0;
    logic [LW-1:0] dem_line = '0;
    logic          dem_merge, dem_done;
    logic [LW-1:0] dem_done_line;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pf_issuer u0 (.*);

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic push_cand(input logic [1:0] k, input logic held, input logic [LW-1:0] ln);
        @(negedge clk);
        cand_valid = 1; cand_kind = k; cand_held = held; cand_line = ln;
        @(negedge clk);
        cand_valid = 0; cand_held = 0;
        #1;
    endtask

    // accept one probe with given hit flag; returns whether memory was requested
    task automatic take_probe(input logic hit, output logic req, output logic [LW-1:0] ln,
                              output logic ex);
        @(negedge clk);
        probe_ready = 1; probe_hit = hit;
        #1;
        req = mem_req_valid; ln = mem_req_line; ex = mem_req_excl;
        @(negedge clk);
        probe_ready = 0; probe_hit = 0;
        #1;
    endtask

    task automatic respond(input logic [LW-1:0] ln, output logic fv, output logic [LW-1:0] fl,
                           output logic fe, output logic dd);
        @(negedge clk);
        mem_rsp_valid = 1; mem_rsp_line = ln;
        @(negedge clk);
        mem_rsp_valid = 0;
        #1;
        fv = fill_valid; fl = fill_line; fe = fill_excl; dd = dem_done;
    endtask

    task automatic t_reset();
        chk(probe_valid == 0, "R4 reset probe", probe_valid, 0);
        chk(mem_req_valid == 0, "R6 reset req", mem_req_valid, 0);
        chk(fill_valid == 0, "R8 reset fill", fill_valid, 0);
        chk(dem_done == 0, "R12 reset done", dem_done, 0);
    endtask

    task automatic t_ignored();
        push_cand(2'd0, 1'b0, 26'h11);
        chk(probe_valid == 0, "R1 not held", probe_valid, 0);
        push_cand(2'd3, 1'b1, 26'h12);
        chk(probe_valid == 0, "R1 kind none", probe_valid, 0);
    endtask

    task automatic t_kinds();
        logic r, e, fv, fe, dd; logic [LW-1:0] l, fl;
        push_cand(2'd0, 1'b1, 26'h100);
        chk(probe_valid == 1, "R4 load probe", probe_valid, 1);
        chk(probe_excl == 0, "R2 load shared", probe_excl, 0);
        chk(probe_line == 26'h100, "R4 probe line", probe_line, 26'h100);
        take_probe(0, r, l, e);
        chk(r == 1 && l == 26'h100 && e == 0, "R6 load miss req", {r, e}, 2'b10);
        respond(26'h100, fv, fl, fe, dd);
        chk(fv == 1 && fl == 26'h100 && fe == 0, "R8 load fill", {fv, fe}, 2'b10);
        chk(dd == 0, "R12 no merge no done", dd, 0);
        push_cand(2'd1, 1'b1, 26'h101);
        chk(probe_excl == 1, "R2 store excl", probe_excl, 1);
        take_probe(0, r, l, e);
        chk(r == 1 && e == 1, "R6 store req excl", {r, e}, 2'b11);
        respond(26'h101, fv, fl, fe, dd);
        chk(fv == 1 && fe == 1, "R8 store fill excl", {fv, fe}, 2'b11);
        push_cand(2'd2, 1'b1, 26'h102);
        chk(probe_valid == 1 && probe_excl == 1, "R2 atomic excl", {probe_valid, probe_excl}, 2'b11);
        take_probe(1, r, l, e);
        chk(r == 0, "R5 hit dropped", r, 0);
        chk(probe_valid == 0, "R5 hit popped", probe_valid, 0);
    endtask

    task automatic t_update();
        logic r, e; logic [LW-1:0] l;
        update_mode = 1;
        push_cand(2'd1, 1'b1, 26'h200);
        chk(probe_valid == 0, "R3 store blocked", probe_valid, 0);
        push_cand(2'd2, 1'b1, 26'h201);
        chk(probe_valid == 0, "R3 atomic blocked", probe_valid, 0);
        push_cand(2'd0, 1'b1, 26'h202);
        chk(probe_valid == 1 && probe_excl == 0, "R3 load passes", {probe_valid, probe_excl}, 2'b10);
        update_mode = 0;
        take_probe(1, r, l, e);
    endtask

    task automatic t_dup_merge();
        logic r, e, fv, fe, dd, m; logic [LW-1:0] l, fl;
        push_cand(2'd0, 1'b1, 26'h300);
        take_probe(0, r, l, e);
        push_cand(2'd1, 1'b1, 26'h300);
        take_probe(0, r, l, e);
        chk(r == 0, "R7 dup in flight dropped", r, 0);
        @(negedge clk);
        dem_valid = 1; dem_line = 26'h300;
        #1; m = dem_merge;
        chk(m == 1, "R9 demand merged", m, 1);
        chk(mem_req_valid == 0, "R9 no demand request", mem_req_valid, 0);
        dem_line = 26'h301;
        #1; m = dem_merge;
        chk(m == 0, "R9 other line not merged", m, 0);
        @(negedge clk);
        dem_valid = 0;
        dem_valid = 1; dem_line = 26'h300;
        @(negedge clk);
        dem_valid = 0;
        respond(26'h300, fv, fl, fe, dd);
        chk(dd == 1 && dem_done_line == 26'h300, "R12 merged done", dd, 1);
        chk(fv == 1 && fe == 0, "R8 merged fill", {fv, fe}, 2'b10);
        respond(26'h3ff, fv, fl, fe, dd);
        chk(fv == 0, "R8 stray response ignored", fv, 0);
    endtask

    task automatic t_full();
        logic r, e, ok; logic [LW-1:0] l;
        for (int i = 0; i < 6; i++) push_cand(2'd0, 1'b1, LW'(26'h400 + i));
        ok = 1;
        for (int i = 0; i < 4; i++) begin
            chk(probe_valid == 1 && probe_line == LW'(26'h400 + i), "R10 order kept",
                probe_line, 26'h400 + i);
            take_probe(1, r, l, e);
        end
        chk(probe_valid == 0, "R10 overflow dropped", probe_valid, 0);
        push_cand(2'd0, 1'b1, 26'h4a0);
        mem_req_ready = 0;
        #1;
        chk(probe_valid == 0, "R4 gated by mem ready", probe_valid, 0);
        mem_req_ready = 1;
        #1;
        chk(probe_valid == 1, "R4 ready restores", probe_valid, 1);
        take_probe(1, r, l, e);
    endtask

    task automatic t_table_full();
        logic r, e, fv, fe, dd; logic [LW-1:0] l, fl;
        for (int i = 0; i < 4; i++) begin
            push_cand(2'd0, 1'b1, LW'(26'h500 + i));
            take_probe(0, r, l, e);
        end
        push_cand(2'd1, 1'b1, 26'h5f0);
        chk(probe_valid == 0, "R11 table full stalls", probe_valid, 0);
        respond(26'h502, fv, fl, fe, dd);
        chk(probe_valid == 1 && probe_line == 26'h5f0, "R11 slot freed", probe_valid, 1);
        take_probe(0, r, l, e);
        chk(r == 1 && l == 26'h5f0 && e == 1, "R6 req after free", {r, e}, 2'b11);
        respond(26'h500, fv, fl, fe, dd);
        respond(26'h501, fv, fl, fe, dd);
        respond(26'h503, fv, fl, fe, dd);
        respond(26'h5f0, fv, fl, fe, dd);
        chk(fv == 1 && fl == 26'h5f0 && fe == 1, "R8 last fill", fl, 26'h5f0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        t_reset();
        t_ignored();
        t_kinds();
        t_update();
        t_dup_merge();
        t_full();
        t_table_full();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule